// File: doc/BRIEF.md
# Port Link Guard

This block decides whether one port's receiver and transmitter are switched on. It watches two event inputs: a strobe for each received beat and a strobe for each illegal symbol. A beat-period tick lets it notice when beats stop arriving. A slow timer tick measures the longer waits. A small control register, loaded through a write strobe and read back on dedicated outputs, selects between two ways of running the port.

In manual mode the controller's own off bits set the enables. Two shutdown enables arm the fault checks. A fault that has been armed latches the port off. The latch stays set until both shutdown enables are written to zero, and the off bits keep the values that were written. In automatic mode the manual bits are ignored. With fault monitoring on, the port starts down and comes up after four sixteenths of a second with no fault. Any fault takes it down again on the next clock. With fault monitoring off, the port runs with no beats required. A status flag reports when an active port has gone the selected timeout period without a beat.

All durations are counted in slow ticks. `SIXTEENTH_TICKS` slow ticks make one sixteenth of a second.

Top module: `link_guard`

## Requirements
- R1: A missing-beat fault is present once three beat-period ticks have been sampled with no beat strobe since the last beat. A beat strobe clears the fault, and a beat in the same cycle as a tick wins.
- R2: In manual mode a missing-beat fault latches the port off only while the missing-beat shutdown enable is 1. An illegal symbol latches it off only while the illegal-symbol shutdown enable is 1. The latch is set on the clock edge after the fault.
- R3: In manual mode `port_off` stays 1 after a fault latch, even when the fault has gone. It returns to 0 one clock after both shutdown enables read 0. While it is 1, `tx_en` and `rx_en` are 0.
- R4: A fault shutdown never changes the read-back off bits or enables. They change only on `ctl_wr`.
- R5: In automatic mode the manual off bits and shutdown enables have no effect on `tx_en`, `rx_en` or `port_off`. In manual mode `tx_en` is the inverse of the transmit-off bit and `rx_en` is the inverse of the receive-off bit, with both gated by the latch.
- R6: In automatic mode with monitoring on, the port is down on entry. It comes up (`auto_port_off` = 0, both enables 1) one clock after the 4*SIXTEENTH_TICKS-th slow tick with no fault. Any fault restarts the count.
- R7: In automatic mode with monitoring on, an illegal symbol or a missing-beat fault drives both enables to 0 on the next clock edge.
- R8: In automatic mode with monitoring off, the port is up one clock after the mode is entered. Illegal symbols and missing beats are ignored.
- R9: Reset (synchronous, `rst_n` low) sets both off bits to 1 and both shutdown enables to 0. It loads the automatic-enable bit from `strap_auto` and the monitoring-enable bit from `strap_mon`.
- R10: `tmo_sel` selects the receive timeout: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64 times SIXTEENTH_TICKS slow ticks. In automatic mode with the port up, `auto_rx_timeout` is 1 once that many slow ticks have been seen since the last beat. A beat clears it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_auto | input | 1 | Reset value of the automatic-enable bit |
| strap_mon | input | 1 | Reset value of the monitoring-enable bit |
| beat_seen | input | 1 | One-cycle strobe per received beat |
| beat_tick | input | 1 | One-cycle strobe per beat period |
| illegal_sym | input | 1 | One-cycle strobe per illegal symbol |
| slow_tick | input | 1 | One-cycle strobe of the slow timebase |
| ctl_wr | input | 1 | Loads the six control bits below |
| wr_tx_off | input | 1 | Transmit-off value to write |
| wr_rx_off | input | 1 | Receive-off value to write |
| wr_miss_sd | input | 1 | Missing-beat shutdown enable to write |
| wr_ill_sd | input | 1 | Illegal-symbol shutdown enable to write |
| wr_auto | input | 1 | Automatic-mode enable to write |
| wr_mon | input | 1 | Automatic fault-monitoring enable to write |
| tmo_sel | input | 2 | Receive timeout select |
| rb_tx_off | output | 1 | Read-back transmit-off bit |
| rb_rx_off | output | 1 | Read-back receive-off bit |
| rb_miss_sd | output | 1 | Read-back missing-beat shutdown enable |
| rb_ill_sd | output | 1 | Read-back illegal-symbol shutdown enable |
| rb_auto | output | 1 | Read-back automatic-mode enable |
| rb_mon | output | 1 | Read-back monitoring enable |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| port_off | output | 1 | Port held off by a fault (manual) or down (automatic) |
| auto_port_off | output | 1 | Automatic-mode port state, 1 = down |
| auto_rx_timeout | output | 1 | Receive timeout flag in automatic mode |

## Verification
A fault latch stuck in the wrong state shows on `port_off` and on both enables. It appears one clock after the fault, or one clock after the shutdown enables are cleared. A quiet-period counter that is too short or too long moves the bring-up edge by whole slow ticks, so the bench checks the enables at the tick just before the expected edge and at the tick just after it. An error in the beat-miss counter or in the timeout selection shifts the edge of `port_off` or `auto_rx_timeout` by one tick period. The shift is visible within a few ticks of the stimulus.

// File: rtl/link_guard_pkg.sv
package link_guard_pkg;
  typedef struct packed {
    logic tx_off;
    logic rx_off;
    logic miss_sd;
    logic ill_sd;
    logic auto_en;
    logic mon_en;
  } guard_ctl_t;

  // Timeout multiple of one sixteenth of a second
  function automatic int unsigned tmo_mult(logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 16;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/lg_beat_watch.sv
module lg_beat_watch #(
  parameter int MISS_BEATS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_seen,
  input  logic beat_tick,
  output logic missing
);
  localparam int CW = $clog2(MISS_BEATS + 1);
  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      gap_cnt <= '0;
    else if (beat_seen)
      gap_cnt <= '0;
    else if (beat_tick && gap_cnt != CW'(MISS_BEATS))
      gap_cnt <= gap_cnt + 1'b1;
  end

  assign missing = (gap_cnt == CW'(MISS_BEATS));
endmodule

// File: rtl/lg_tick_timer.sv
module lg_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt <= '0;
    else if (tick && cnt < limit)
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt >= limit);
endmodule

// File: rtl/link_guard.sv
module link_guard
  import link_guard_pkg::*;
#(
  parameter int SIXTEENTH_TICKS = 625,
  parameter int MISS_BEATS      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_auto,
  input  logic       strap_mon,
  input  logic       beat_seen,
  input  logic       beat_tick,
  input  logic       illegal_sym,
  input  logic       slow_tick,
  input  logic       ctl_wr,
  input  logic       wr_tx_off,
  input  logic       wr_rx_off,
  input  logic       wr_miss_sd,
  input  logic       wr_ill_sd,
  input  logic       wr_auto,
  input  logic       wr_mon,
  input  logic [1:0] tmo_sel,
  output logic       rb_tx_off,
  output logic       rb_rx_off,
  output logic       rb_miss_sd,
  output logic       rb_ill_sd,
  output logic       rb_auto,
  output logic       rb_mon,
  output logic       tx_en,
  output logic       rx_en,
  output logic       port_off,
  output logic       auto_port_off,
  output logic       auto_rx_timeout
);
  localparam int MAX_TICKS = 64 * SIXTEENTH_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int QUIET     = 4 * SIXTEENTH_TICKS;

  guard_ctl_t ctl;
  logic       missing, fault, fault_latch, auto_down;
  logic       quiet_done, quiet_clr, rxto_clr;
  logic [CNT_W-1:0] rxto_limit;

  // Control register
  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl <= '{tx_off: 1'b1, rx_off: 1'b1, miss_sd: 1'b0, ill_sd: 1'b0,
               auto_en: strap_auto, mon_en: strap_mon};
    else if (ctl_wr)
      ctl <= '{tx_off: wr_tx_off, rx_off: wr_rx_off, miss_sd: wr_miss_sd,
               ill_sd: wr_ill_sd, auto_en: wr_auto, mon_en: wr_mon};
  end

  lg_beat_watch #(.MISS_BEATS(MISS_BEATS)) u_watch (
    .clk(clk), .rst_n(rst_n), .beat_seen(beat_seen),
    .beat_tick(beat_tick), .missing(missing)
  );

  assign fault = missing | illegal_sym;

  // Manual-mode sticky shutdown
  always_ff @(posedge clk) begin
    if (!rst_n)
      fault_latch <= 1'b0;
    else if (ctl.auto_en || (!ctl.miss_sd && !ctl.ill_sd))
      fault_latch <= 1'b0;
    else if ((missing && ctl.miss_sd) || (illegal_sym && ctl.ill_sd))
      fault_latch <= 1'b1;
  end

  // Automatic-mode bring-up and shutdown
  assign quiet_clr = !ctl.auto_en || !ctl.mon_en || fault || !auto_down;

  lg_tick_timer #(.W(CNT_W)) u_quiet (
    .clk(clk), .rst_n(rst_n), .clr(quiet_clr), .tick(slow_tick),
    .limit(CNT_W'(QUIET)), .done(quiet_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !ctl.auto_en)
      auto_down <= 1'b1;
    else if (!ctl.mon_en)
      auto_down <= 1'b0;
    else if (fault)
      auto_down <= 1'b1;
    else if (quiet_done)
      auto_down <= 1'b0;
  end

  // Receive timeout
  assign rxto_limit = CNT_W'(tmo_mult(tmo_sel) * SIXTEENTH_TICKS);
  assign rxto_clr   = !ctl.auto_en || auto_down || beat_seen;

  lg_tick_timer #(.W(CNT_W)) u_rxto (
    .clk(clk), .rst_n(rst_n), .clr(rxto_clr), .tick(slow_tick),
    .limit(rxto_limit), .done(auto_rx_timeout)
  );

  // Outputs
  assign tx_en = ctl.auto_en ? !auto_down : (!ctl.tx_off && !fault_latch);
  assign rx_en = ctl.auto_en ? !auto_down : (!ctl.rx_off && !fault_latch);
  assign port_off      = ctl.auto_en ? auto_down : fault_latch;
  assign auto_port_off = auto_down;

  assign rb_tx_off  = ctl.tx_off;
  assign rb_rx_off  = ctl.rx_off;
  assign rb_miss_sd = ctl.miss_sd;
  assign rb_ill_sd  = ctl.ill_sd;
  assign rb_auto    = ctl.auto_en;
  assign rb_mon     = ctl.mon_en;
endmodule

// File: rtl/link_guard_chk.sv
module link_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic illegal_sym,
  input logic ctl_wr,
  input logic rb_tx_off,
  input logic rb_rx_off,
  input logic rb_miss_sd,
  input logic rb_ill_sd,
  input logic rb_auto,
  input logic rb_mon,
  input logic tx_en,
  input logic rx_en,
  input logic port_off
);
  AST_AUTO_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_auto && rb_mon && illegal_sym && !ctl_wr) |=> (!tx_en && !rx_en)); // R7

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_auto && port_off && (rb_miss_sd || rb_ill_sd) && !ctl_wr) |=> port_off); // R3

  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_auto && !rb_miss_sd && !rb_ill_sd && !ctl_wr) |=> !port_off); // R3

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable({rb_tx_off, rb_rx_off, rb_miss_sd, rb_ill_sd, rb_auto, rb_mon})); // R4

  AST_UNMONITORED_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_auto && !rb_mon && !ctl_wr) |=> (tx_en && rx_en)); // R8
endmodule

bind link_guard link_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .illegal_sym(illegal_sym), .ctl_wr(ctl_wr),
  .rb_tx_off(rb_tx_off), .rb_rx_off(rb_rx_off), .rb_miss_sd(rb_miss_sd),
  .rb_ill_sd(rb_ill_sd), .rb_auto(rb_auto), .rb_mon(rb_mon),
  .tx_en(tx_en), .rx_en(rx_en), .port_off(port_off)
);

// File: tb/link_guard_test.sv
module link_guard_test;
  localparam int PERIOD = 10;
  localparam int SIX    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_auto = 1'b0, strap_mon = 1'b0;
  logic beat_seen = 1'b0, beat_tick = 1'b0, illegal_sym = 1'b0, slow_tick = 1'b0;
  logic ctl_wr = 1'b0;
  logic wr_tx_off = 1'b0, wr_rx_off = 1'b0, wr_miss_sd = 1'b0, wr_ill_sd = 1'b0;
  logic wr_auto = 1'b0, wr_mon = 1'b0;
  logic [1:0] tmo_sel = 2'b00;
  logic rb_tx_off, rb_rx_off, rb_miss_sd, rb_ill_sd, rb_auto, rb_mon;
  logic tx_en, rx_en, port_off, auto_port_off, auto_rx_timeout;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  link_guard #(.SIXTEENTH_TICKS(SIX), .MISS_BEATS(3)) uut (
    .clk(clk), .rst_n(rst_n), .strap_auto(strap_auto), .strap_mon(strap_mon),
    .beat_seen(beat_seen), .beat_tick(beat_tick), .illegal_sym(illegal_sym),
    .slow_tick(slow_tick), .ctl_wr(ctl_wr), .wr_tx_off(wr_tx_off),
    .wr_rx_off(wr_rx_off), .wr_miss_sd(wr_miss_sd), .wr_ill_sd(wr_ill_sd),
    .wr_auto(wr_auto), .wr_mon(wr_mon), .tmo_sel(tmo_sel),
    .rb_tx_off(rb_tx_off), .rb_rx_off(rb_rx_off), .rb_miss_sd(rb_miss_sd),
    .rb_ill_sd(rb_ill_sd), .rb_auto(rb_auto), .rb_mon(rb_mon),
    .tx_en(tx_en), .rx_en(rx_en), .port_off(port_off),
    .auto_port_off(auto_port_off), .auto_rx_timeout(auto_rx_timeout)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write(input logic txo, rxo, msd, isd, au, mo);
    wr_tx_off = txo; wr_rx_off = rxo; wr_miss_sd = msd; wr_ill_sd = isd;
    wr_auto = au; wr_mon = mo; ctl_wr = 1'b1;
    step();
    ctl_wr = 1'b0;
  endtask

  task automatic pulse_slow(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1'b1; step(); slow_tick = 1'b0;
    end
  endtask

  // Expected next manual latch from R2/R3, illegal-symbol path only
  function automatic logic next_latch(logic cur, logic msd, logic isd, logic ill);
    if (!msd && !isd) return 1'b0;
    if (ill && isd) return 1'b1;
    return cur;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic lat, msd, isd;
    void'($urandom(32'd1234));
    // R9 reset state, straps low
    repeat (2) step();
    rst_n = 1'b1; step();
    chk({rb_tx_off, rb_rx_off, rb_miss_sd, rb_ill_sd, rb_auto, rb_mon}, 6'b110000, "R9 reset ctl");
    chk({tx_en, rx_en, port_off}, 3'b000, "R9 reset enables");
    // R9 straps high
    rst_n = 1'b0; strap_auto = 1'b1; strap_mon = 1'b1; step();
    rst_n = 1'b1; strap_auto = 1'b0; strap_mon = 1'b0; step();
    chk({rb_auto, rb_mon, rb_tx_off}, 3'b111, "R9 strap capture");

    // R5 manual mode: off bits drive enables
    write(0, 1, 0, 0, 0, 0); step();
    chk({tx_en, rx_en}, 2'b10, "R5 manual off bits");
    write(0, 0, 0, 0, 0, 0);
    // R2 illegal ignored without enable
    illegal_sym = 1'b1; step(); illegal_sym = 1'b0; step();
    chk({port_off, tx_en}, 2'b01, "R2 illegal without enable");

    // R1 / R2 missing beat with enable
    write(0, 0, 1, 0, 0, 0);
    beat_seen = 1'b1; step(); beat_seen = 1'b0;
    beat_tick = 1'b1; step(); step(); beat_tick = 1'b0; step();
    chk(port_off, 1'b0, "R1 two beat ticks no fault");
    beat_tick = 1'b1; beat_seen = 1'b1; step(); beat_seen = 1'b0; beat_tick = 1'b0; step();
    chk(port_off, 1'b0, "R1 beat wins over tick");
    beat_tick = 1'b1; step(); step(); step(); beat_tick = 1'b0; step();
    chk({port_off, tx_en, rx_en}, 3'b100, "R1 R2 three ticks shutdown");
    chk({rb_tx_off, rb_rx_off, rb_miss_sd}, 3'b001, "R4 readback unchanged");
    // R3 sticky after fault clears
    beat_seen = 1'b1; step(); beat_seen = 1'b0; step(); step();
    chk(port_off, 1'b1, "R3 latch sticky");
    write(0, 0, 0, 0, 0, 0);
    chk(port_off, 1'b1, "R3 clear takes one clock");
    step();
    chk({port_off, tx_en}, 2'b01, "R3 cleared by enables");

    // R2 random manual illegal-symbol sequence
    lat = 1'b0; msd = 1'b0; isd = 1'b0;
    for (int i = 0; i < 300; i++) begin
      logic ill, w, nm, ni;
      ill = ($urandom % 4) == 0;
      w   = ($urandom % 6) == 0;
      nm  = $urandom % 2;
      ni  = $urandom % 2;
      illegal_sym = ill;
      wr_tx_off = 1'b0; wr_rx_off = 1'b0; wr_miss_sd = nm; wr_ill_sd = ni;
      wr_auto = 1'b0; wr_mon = 1'b0; ctl_wr = w;
      lat = next_latch(lat, msd, isd, ill);
      if (w) begin msd = nm; isd = ni; end
      step();
      ctl_wr = 1'b0; illegal_sym = 1'b0;
      chk({port_off, tx_en}, {lat, ~lat}, "R2 random illegal shutdown");
    end
    write(0, 0, 0, 0, 0, 0); step();

    // R6 automatic bring-up, manual bits ignored (R5)
    write(1, 1, 1, 1, 1, 1);
    chk({tx_en, auto_port_off}, 2'b01, "R6 auto starts down");
    pulse_slow(4*SIX - 1); step();
    chk(tx_en, 1'b0, "R6 not up before quarter");
    pulse_slow(1);
    step();
    chk({tx_en, rx_en, auto_port_off, port_off}, 4'b1100, "R6 R5 up after quarter");
    // R7 illegal drops
    illegal_sym = 1'b1; step(); illegal_sym = 1'b0;
    chk({tx_en, rx_en}, 2'b00, "R7 illegal drops port");
    // R6 fault restarts count
    pulse_slow(4*SIX - 1);
    illegal_sym = 1'b1; step(); illegal_sym = 1'b0;
    pulse_slow(2); step();
    chk(tx_en, 1'b0, "R6 fault restarts quiet count");
    pulse_slow(4*SIX); step();
    chk(tx_en, 1'b1, "R6 up after fresh quarter");

    // R10 timeouts
    tmo_sel = 2'b00;
    beat_seen = 1'b1; step(); beat_seen = 1'b0;
    pulse_slow(SIX - 1);
    chk(auto_rx_timeout, 1'b0, "R10 sel00 before limit");
    pulse_slow(1);
    chk(auto_rx_timeout, 1'b1, "R10 sel00 at limit");
    beat_seen = 1'b1; step(); beat_seen = 1'b0;
    chk(auto_rx_timeout, 1'b0, "R10 beat clears");
    tmo_sel = 2'b10;
    pulse_slow(16*SIX - 1);
    chk(auto_rx_timeout, 1'b0, "R10 sel10 before limit");
    pulse_slow(1);
    chk(auto_rx_timeout, 1'b1, "R10 sel10 at limit");
    tmo_sel = 2'b01; beat_seen = 1'b1; step(); beat_seen = 1'b0;
    pulse_slow(4*SIX - 1);
    chk(auto_rx_timeout, 1'b0, "R10 sel01 before limit");
    pulse_slow(1);
    chk(auto_rx_timeout, 1'b1, "R10 sel01 at limit");

    // R8 monitoring off: up at once, faults ignored
    write(1, 1, 0, 0, 0, 0); step();
    chk(tx_en, 1'b0, "R5 back to manual off");
    write(1, 1, 1, 1, 1, 0);
    step();
    chk({tx_en, rx_en}, 2'b11, "R8 up without beats");
    illegal_sym = 1'b1; step(); illegal_sym = 1'b0;
    beat_tick = 1'b1; repeat (4) step(); beat_tick = 1'b0; step();
    chk({tx_en, rx_en, port_off}, 3'b110, "R8 faults ignored");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule